// File: doc/BRIEF.md
# Serial Receive Path with Three-Entry Holding Queue

This block turns an oversampled asynchronous serial line into 8-bit characters and keeps them in a three-place holding queue. A host reads the queue through a read port. The line is sampled on a clock enable that pulses sixteen times per bit. A falling edge is confirmed as a start bit only if the line is still low at the middle of the bit. Eight data bits follow, least significant first. An optional parity bit comes next, then one stop bit. Each stored character carries its own parity-error and framing-error flags. The data and flags of the oldest character are always visible at the outputs.

The queue holds three characters. When it is full, the deserializer holds one more completed character in place until a read frees a slot. If another character then arrives, the held character is lost, and a sticky overrun flag is raised. The flag rises as soon as the start bit of the overrunning character is confirmed, not when that character ends. An optional flow-control output deasserts when a start bit is confirmed while the queue is full. It reasserts as soon as a slot frees up. Three single-cycle commands control the receiver: enable, disable and reset. Reading the status outputs never changes the queue. Only a pulse on the buffer read strobe removes the oldest character.

Top module: `serial_rx_queue`

## Requirements
- R1: A high-to-low line transition starts a frame only if the line is still low 8 ticks later. The next 8 bits are taken mid-bit, least significant bit first, and appear on `rx_data` in order of arrival.
- R2: With `par_en`=1 a parity bit follows the data. With `par_odd`=0 the count of ones in data plus parity must be even; with `par_odd`=1 it must be odd. A mismatch sets `rx_perr` for that character only. With `par_en`=0 `rx_perr` is 0.
- R3: A stop bit sampled low sets `rx_ferr` for that character only. A new frame is recognised only after the line has been seen high again.
- R4: The queue keeps three characters and is read oldest first. `rx_full`=1 when three are stored. A read in the same cycle as a character arrival loses no character.
- R5: A character that completes while the queue is full waits in the deserializer. It enters the queue when a read frees a slot, with no overrun raised.
- R6: If a start bit is confirmed while a character is waiting and no read frees a slot in that cycle, `overrun` rises at that start bit. The waiting character is replaced by the new one and the queue is unchanged. `overrun` stays set until a reset command.
- R7: Only a `buf_rd` pulse on a non-empty queue removes the head. `buf_rd` on an empty queue has no effect, and the head outputs stay stable while there is no read.
- R8: `rts`=1 means asserted. With `auto_rts`=1, `rts` falls one cycle after a start bit is confirmed while the queue is full and no read occurs. It rises in the cycle after a read or whenever the queue is not full. With `auto_rts`=0 `rts` stays 1.
- R9: After `cmd_disable` no new character is accepted, and characters already queued can still be read.
- R10: `cmd_reset` (and `rst_n` low) empties the queue, drops any waiting character, clears `overrun`, sets `rts` to 1 and leaves the receiver disabled until `cmd_enable`.
- R11: A low pulse shorter than 8 ticks returns the receiver to idle and produces no character.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick16 | input | 1 | Oversample enable, 16 pulses per bit |
| rxd | input | 1 | Serial line, idle high |
| cmd_enable | input | 1 | Pulse: enable the receiver |
| cmd_disable | input | 1 | Pulse: disable the receiver |
| cmd_reset | input | 1 | Pulse: reset the receiver state |
| par_en | input | 1 | Parity bit present |
| par_odd | input | 1 | 1 = odd parity, 0 = even |
| auto_rts | input | 1 | Enable automatic flow control |
| buf_rd | input | 1 | Pop the oldest character |
| rx_data | output | 8 | Data of the head character |
| rx_perr | output | 1 | Parity error of the head character |
| rx_ferr | output | 1 | Framing error of the head character |
| rx_valid | output | 1 | Queue not empty |
| rx_full | output | 1 | Queue holds three characters |
| overrun | output | 1 | Sticky overrun flag |
| rts | output | 1 | Flow-control output, 1 = asserted |

## Verification
Two events can fall in the same clock cycle: a host read that pops the queue, and the deserializer finishing a character that must be pushed. The bench places one character in the queue and sends a second. It issues a single read at every clock offset across a window around the second character's stop-bit sample, so the read lands before, on and after the push cycle. Each time it checks that the read returned the first character, that the second is then at the head, and that the queue is empty after that. The same reasoning covers the start-bit-versus-read case. An overrun is expected only when the parked character still finds the queue full.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
  localparam int unsigned CHAR_W = 8;

  typedef struct packed {
    logic [CHAR_W-1:0] data;
    logic              perr;
    logic              ferr;
  } rx_char_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PAR,
    ST_STOP
  } rx_state_e;
endpackage

// File: rtl/rxq_sync.sv
module rxq_sync #(
  parameter int unsigned STAGES  = 2,
  parameter bit          RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] stage_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q <= RST_VAL;
        else        stage_q <= d;
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q <= {STAGES{RST_VAL}};
        else        stage_q <= {stage_q[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/rxq_deser.sv
module rxq_deser
  import rxq_pkg::*;
#(
  parameter int unsigned OVS = 16
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     run,
  input  logic     tick,
  input  logic     rxd_s,
  input  logic     par_en,
  input  logic     par_odd,
  output logic     start_ok,
  output logic     char_done,
  output rx_char_t char_o
);
  localparam int unsigned CW = $clog2(OVS);
  localparam int unsigned BW = $clog2(CHAR_W);
  localparam logic [CW-1:0] HALF_M1 = CW'(OVS/2 - 1);
  localparam logic [CW-1:0] LAST    = CW'(OVS - 1);
  localparam logic [BW-1:0] BIT_END = BW'(CHAR_W - 1);

  rx_state_e         state_q, state_n;
  logic [CW-1:0]     cnt_q, cnt_n;
  logic [BW-1:0]     bidx_q, bidx_n;
  logic [CHAR_W-1:0] sh_q, sh_n;
  logic              pbit_q, pbit_n;
  logic              hi_q, hi_n;

  always_comb begin
    state_n   = state_q;
    cnt_n     = cnt_q;
    bidx_n    = bidx_q;
    sh_n      = sh_q;
    pbit_n    = pbit_q;
    hi_n      = hi_q;
    start_ok  = 1'b0;
    char_done = 1'b0;
    if (!run) begin
      state_n = ST_IDLE;
      cnt_n   = '0;
      hi_n    = 1'b0;
    end else if (tick) begin
      hi_n = rxd_s;
      case (state_q)
        ST_IDLE: begin
          if (hi_q && !rxd_s) begin
            state_n = ST_START;
            cnt_n   = '0;
          end
        end
        ST_START: begin
          if (cnt_q == HALF_M1) begin
            cnt_n = '0;
            if (!rxd_s) begin
              start_ok = 1'b1;
              state_n  = ST_DATA;
              bidx_n   = '0;
            end else begin
              state_n = ST_IDLE;
            end
          end else begin
            cnt_n = cnt_q + 1'b1;
          end
        end
        ST_DATA: begin
          if (cnt_q == LAST) begin
            cnt_n = '0;
            sh_n  = {rxd_s, sh_q[CHAR_W-1:1]};
            if (bidx_q == BIT_END) state_n = par_en ? ST_PAR : ST_STOP;
            else                   bidx_n  = bidx_q + 1'b1;
          end else begin
            cnt_n = cnt_q + 1'b1;
          end
        end
        ST_PAR: begin
          if (cnt_q == LAST) begin
            cnt_n   = '0;
            pbit_n  = rxd_s;
            state_n = ST_STOP;
          end else begin
            cnt_n = cnt_q + 1'b1;
          end
        end
        ST_STOP: begin
          if (cnt_q == LAST) begin
            cnt_n     = '0;
            char_done = 1'b1;
            state_n   = ST_IDLE;
          end else begin
            cnt_n = cnt_q + 1'b1;
          end
        end
        default: state_n = ST_IDLE;
      endcase
    end
  end

  always_comb begin
    char_o.data = sh_q;
    char_o.perr = par_en && (pbit_q != ((^sh_q) ^ par_odd));
    char_o.ferr = !rxd_s;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      bidx_q  <= '0;
      sh_q    <= '0;
      pbit_q  <= 1'b0;
      hi_q    <= 1'b0;
    end else begin
      state_q <= state_n;
      cnt_q   <= cnt_n;
      bidx_q  <= bidx_n;
      sh_q    <= sh_n;
      pbit_q  <= pbit_n;
      hi_q    <= hi_n;
    end
  end

  // R1: a confirmed start and a finished character never share a cycle
  a_r1_start_done_apart: assert property (@(posedge clk) disable iff (!rst_n)
    !(start_ok && char_done));

  // R3: no start is taken unless the line was seen high on the previous tick
  a_r3_start_needs_high: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE && state_n == ST_START) |-> hi_q);
endmodule

// File: rtl/rxq_fifo.sv
module rxq_fifo
  import rxq_pkg::*;
#(
  parameter int unsigned DEPTH = 3
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     clear,
  input  logic     push,
  input  logic     pop,
  input  rx_char_t din,
  output rx_char_t head,
  output logic     empty,
  output logic     full,
  output logic     pop_act
);
  localparam int unsigned PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CNTW = $clog2(DEPTH + 1);
  localparam logic [PW-1:0]   PTR_END  = PW'(DEPTH - 1);
  localparam logic [CNTW-1:0] CNT_FULL = CNTW'(DEPTH);

  rx_char_t        mem_q [DEPTH];
  logic [PW-1:0]   rd_q, rd_n, wr_q, wr_n;
  logic [CNTW-1:0] cnt_q, cnt_n;
  logic            wr_en;

  function automatic logic [PW-1:0] step(input logic [PW-1:0] p);
    return (p == PTR_END) ? '0 : p + 1'b1;
  endfunction

  assign empty   = (cnt_q == '0);
  assign full    = (cnt_q == CNT_FULL);
  assign pop_act = pop && !empty && !clear;
  assign wr_en   = push && !clear;
  assign head    = mem_q[rd_q];

  always_comb begin
    rd_n  = rd_q;
    wr_n  = wr_q;
    cnt_n = cnt_q;
    if (clear) begin
      rd_n  = '0;
      wr_n  = '0;
      cnt_n = '0;
    end else begin
      if (pop_act) rd_n = step(rd_q);
      if (wr_en)   wr_n = step(wr_q);
      if (wr_en && !pop_act)      cnt_n = cnt_q + 1'b1;
      else if (!wr_en && pop_act) cnt_n = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q  <= '0;
      wr_q  <= '0;
      cnt_q <= '0;
    end else begin
      rd_q  <= rd_n;
      wr_q  <= wr_n;
      cnt_q <= cnt_n;
    end
  end

  generate
    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                             mem_q[g] <= '0;
        else if (wr_en && wr_q == PW'(g))       mem_q[g] <= din;
      end
    end
  endgenerate

  // R4: a push is only offered when a slot exists or one is freed in the same cycle
  a_r4_push_has_room: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> (!full || pop_act));

  // R7: without a pop the head entry does not move
  a_r7_head_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (!pop && !empty && !clear) |=> $stable(head));

  // R10: clearing leaves the queue empty
  a_r10_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> empty);
endmodule

// File: rtl/serial_rx_queue.sv
module serial_rx_queue
  import rxq_pkg::*;
#(
  parameter int unsigned OVS         = 16,
  parameter int unsigned DEPTH       = 3,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick16,
  input  logic              rxd,
  input  logic              cmd_enable,
  input  logic              cmd_disable,
  input  logic              cmd_reset,
  input  logic              par_en,
  input  logic              par_odd,
  input  logic              auto_rts,
  input  logic              buf_rd,
  output logic [CHAR_W-1:0] rx_data,
  output logic              rx_perr,
  output logic              rx_ferr,
  output logic              rx_valid,
  output logic              rx_full,
  output logic              overrun,
  output logic              rts
);
  logic     en_q, en_n;
  logic     hold_vld_q, hold_vld_n;
  rx_char_t hold_q, hold_n;
  logic     ovr_q, ovr_n;
  logic     rts_q, rts_n;

  logic     rxd_s, run, start_ok, char_done;
  rx_char_t rx_new, head, push_d;
  logic     push, fifo_empty, fifo_full, pop_act, slot_free;

  rxq_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(rxd), .q(rxd_s)
  );

  assign run = en_q && !cmd_reset;

  rxq_deser #(.OVS(OVS)) u_deser (
    .clk(clk), .rst_n(rst_n), .run(run), .tick(tick16), .rxd_s(rxd_s),
    .par_en(par_en), .par_odd(par_odd),
    .start_ok(start_ok), .char_done(char_done), .char_o(rx_new)
  );

  rxq_fifo #(.DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n), .clear(cmd_reset), .push(push), .pop(buf_rd),
    .din(push_d), .head(head), .empty(fifo_empty), .full(fifo_full),
    .pop_act(pop_act)
  );

  assign slot_free = !fifo_full || pop_act;

  always_comb begin
    en_n = en_q;
    if (cmd_reset || cmd_disable) en_n = 1'b0;
    else if (cmd_enable)          en_n = 1'b1;
  end

  always_comb begin
    push       = 1'b0;
    push_d     = hold_q;
    hold_vld_n = hold_vld_q;
    hold_n     = hold_q;
    if (hold_vld_q) begin
      if (slot_free) begin
        push       = 1'b1;
        push_d     = hold_q;
        hold_vld_n = char_done;
        if (char_done) hold_n = rx_new;
      end else if (char_done) begin
        hold_n = rx_new;
      end
    end else if (char_done) begin
      if (slot_free) begin
        push   = 1'b1;
        push_d = rx_new;
      end else begin
        hold_vld_n = 1'b1;
        hold_n     = rx_new;
      end
    end
    if (cmd_reset) begin
      push       = 1'b0;
      hold_vld_n = 1'b0;
    end
  end

  always_comb begin
    if (cmd_reset) ovr_n = 1'b0;
    else           ovr_n = ovr_q || (start_ok && hold_vld_q && !slot_free);
  end

  always_comb begin
    rts_n = rts_q;
    if (cmd_reset || !auto_rts || slot_free) rts_n = 1'b1;
    else if (start_ok)                       rts_n = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q       <= 1'b0;
      hold_vld_q <= 1'b0;
      hold_q     <= '0;
      ovr_q      <= 1'b0;
      rts_q      <= 1'b1;
    end else begin
      en_q       <= en_n;
      hold_vld_q <= hold_vld_n;
      hold_q     <= hold_n;
      ovr_q      <= ovr_n;
      rts_q      <= rts_n;
    end
  end

  assign rx_data  = head.data;
  assign rx_perr  = head.perr;
  assign rx_ferr  = head.ferr;
  assign rx_valid = !fifo_empty;
  assign rx_full  = fifo_full;
  assign overrun  = ovr_q;
  assign rts      = rts_q;

  // R6: overrun only rises after a start confirmed while a character waited on a full queue
  a_r6_ovr_on_start: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovr_q) |-> $past(start_ok && hold_vld_q && fifo_full));

  // R8: flow control only drops after a start bit seen with the queue full
  a_r8_rts_drop_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rts_q) |-> $past(start_ok && fifo_full && auto_rts));

  // R9: no character completes while the receiver is off
  a_r9_no_char_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    char_done |-> en_q);

  // R10: the reset command clears flags, the parked character and the enable
  a_r10_reset_clears: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_reset |=> (!ovr_q && rts_q && !hold_vld_q && !en_q && !rx_valid));

  // R5: a parked character never coexists with spare room in the queue for long
  a_r5_park_only_when_full: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_vld_q && !fifo_full) |=> !(hold_vld_q && $past(hold_vld_q) && !$past(char_done) && !$past(cmd_reset)));
endmodule

// File: tb/serial_rx_queue_test.sv
`timescale 1ns/1ps
module serial_rx_queue_test;
  localparam int BITC = 16;

  logic clk = 1'b0;
  logic rst_n, tick16, rxd, cmd_enable, cmd_disable, cmd_reset;
  logic par_en, par_odd, auto_rts, buf_rd;
  logic [7:0] rx_data;
  logic rx_perr, rx_ferr, rx_valid, rx_full, overrun, rts;

  int nchk = 0;
  int nerr = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  serial_rx_queue uut (
    .clk(clk), .rst_n(rst_n), .tick16(tick16), .rxd(rxd),
    .cmd_enable(cmd_enable), .cmd_disable(cmd_disable), .cmd_reset(cmd_reset),
    .par_en(par_en), .par_odd(par_odd), .auto_rts(auto_rts), .buf_rd(buf_rd),
    .rx_data(rx_data), .rx_perr(rx_perr), .rx_ferr(rx_ferr),
    .rx_valid(rx_valid), .rx_full(rx_full), .overrun(overrun), .rts(rts)
  );

  task automatic chk(input string rq, input string what, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_bit(input logic v);
    rxd = v;
    repeat (BITC) @(negedge clk);
  endtask

  task automatic send_rest(input logic [7:0] d, input logic pon, input logic pv, input logic sv);
    for (int b = 0; b < 8; b++) send_bit(d[b]);
    if (pon) send_bit(pv);
    send_bit(sv);
    rxd = 1'b1;
    idle(sv ? 4 : 8);
  endtask

  task automatic frame(input logic [7:0] d);
    send_bit(1'b0);
    send_rest(d, 1'b0, 1'b0, 1'b1);
  endtask

  task automatic pulse(ref logic s);
    s = 1'b1;
    @(negedge clk);
    s = 1'b0;
    idle(2);
  endtask

  task automatic read_chk(input string rq, input logic [7:0] ed, input logic epe, input logic efe);
    chk(rq, "valid", rx_valid, 1);
    chk(rq, "data", rx_data, ed);
    chk(rq, "perr", rx_perr, epe);
    chk(rq, "ferr", rx_ferr, efe);
    pulse(buf_rd);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      nerr++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; tick16 = 1'b1; rxd = 1'b1;
    cmd_enable = 1'b0; cmd_disable = 1'b0; cmd_reset = 1'b0;
    par_en = 1'b0; par_odd = 1'b0; auto_rts = 1'b0; buf_rd = 1'b0;
    idle(5);
    rst_n = 1'b1;
    idle(2);
    chk("R10", "reset valid", rx_valid, 0);
    chk("R10", "reset full", rx_full, 0);
    chk("R10", "reset overrun", overrun, 0);
    chk("R10", "reset rts", rts, 1);

    pulse(cmd_enable);
    idle(20);

    // R1 R2 R3: every byte, cycling parity modes, with bad parity and low stop injected
    for (int i = 0; i < 256; i++) begin
      logic [7:0] d;
      int m;
      logic bad, pv, sv;
      d   = 8'(i);
      m   = i % 3;
      bad = (i % 7 == 0);
      sv  = (i % 5 != 0);
      par_en  = (m != 0);
      par_odd = (m == 2);
      pv = (^d) ^ (m == 2) ^ bad;
      send_bit(1'b0);
      send_rest(d, m != 0, pv, sv);
      chk("R1", "data", rx_data, d);
      chk("R2", "parity flag", rx_perr, (m != 0) && bad);
      chk("R3", "framing flag", rx_ferr, !sv);
      read_chk("R1", d, (m != 0) && bad, !sv);
      chk("R1", "single entry", rx_valid, 0);
    end
    par_en = 1'b0; par_odd = 1'b0;

    // R11: short glitch
    rxd = 1'b0; idle(5); rxd = 1'b1; idle(40);
    chk("R11", "glitch ignored", rx_valid, 0);
    frame(8'hA5);
    read_chk("R11", 8'hA5, 1'b0, 1'b0);
    chk("R11", "only one char", rx_valid, 0);

    // R7: read of empty queue has no effect
    pulse(buf_rd);
    frame(8'h66);
    read_chk("R7", 8'h66, 1'b0, 1'b0);
    chk("R7", "empty after one read", rx_valid, 0);

    // R5 and R8 with flow control off: fourth char parks and survives
    auto_rts = 1'b0;
    frame(8'h71); frame(8'h72); frame(8'h73);
    chk("R4", "full at three", rx_full, 1);
    send_bit(1'b0);
    chk("R8", "rts stays asserted with auto off", rts, 1);
    send_rest(8'h74, 1'b0, 1'b0, 1'b1);
    for (int t = 0; t < 40; t++) begin
      @(negedge clk);
      if (rx_data != 8'h71) chk("R7", "head stable", rx_data, 8'h71);
    end
    chk("R7", "head stable after wait", rx_data, 8'h71);
    read_chk("R5", 8'h71, 1'b0, 1'b0);
    read_chk("R5", 8'h72, 1'b0, 1'b0);
    read_chk("R5", 8'h73, 1'b0, 1'b0);
    read_chk("R5", 8'h74, 1'b0, 1'b0);
    chk("R5", "no overrun", overrun, 0);
    chk("R5", "drained", rx_valid, 0);

    // R6 and R8 with flow control on
    auto_rts = 1'b1;
    frame(8'h11); frame(8'h22); frame(8'h33);
    chk("R8", "rts held before start", rts, 1);
    send_bit(1'b0);
    chk("R8", "rts dropped on start while full", rts, 0);
    chk("R5", "parking raises no overrun", overrun, 0);
    send_rest(8'h44, 1'b0, 1'b0, 1'b1);
    send_bit(1'b0);
    chk("R6", "overrun at start bit", overrun, 1);
    send_rest(8'h55, 1'b0, 1'b0, 1'b1);
    chk("R6", "queue still full", rx_full, 1);
    read_chk("R6", 8'h11, 1'b0, 1'b0);
    chk("R8", "rts back after read", rts, 1);
    read_chk("R6", 8'h22, 1'b0, 1'b0);
    read_chk("R6", 8'h33, 1'b0, 1'b0);
    read_chk("R6", 8'h55, 1'b0, 1'b0);
    chk("R6", "parked char discarded", rx_valid, 0);
    chk("R6", "overrun sticky", overrun, 1);

    // R10: reset command with full queue, parked char, overrun and rts low
    frame(8'h81); frame(8'h82); frame(8'h83);
    send_bit(1'b0);
    send_rest(8'h84, 1'b0, 1'b0, 1'b1);
    chk("R8", "rts low before reset", rts, 0);
    pulse(cmd_reset);
    chk("R10", "valid cleared", rx_valid, 0);
    chk("R10", "full cleared", rx_full, 0);
    chk("R10", "overrun cleared", overrun, 0);
    chk("R10", "rts asserted", rts, 1);
    frame(8'h99);
    chk("R10", "no rx until enable", rx_valid, 0);
    pulse(cmd_enable);
    idle(10);
    frame(8'h9A);
    read_chk("R10", 8'h9A, 1'b0, 1'b0);
    chk("R10", "parked char gone", rx_valid, 0);

    // R9: disable keeps queued characters readable
    frame(8'hC1); frame(8'hC2);
    pulse(cmd_disable);
    frame(8'hC3);
    read_chk("R9", 8'hC1, 1'b0, 1'b0);
    read_chk("R9", 8'hC2, 1'b0, 1'b0);
    chk("R9", "no new char while off", rx_valid, 0);
    pulse(cmd_enable);
    idle(10);

    // R4: read at every offset around the arrival of a second character
    for (int k = 140; k < 164; k++) begin
      logic [7:0] a, b;
      a = 8'(k);
      b = ~8'(k);
      frame(a);
      fork
        begin
          send_bit(1'b0);
          send_rest(b, 1'b0, 1'b0, 1'b1);
        end
        begin
          idle(k);
          chk("R4", "head before read", rx_data, a);
          buf_rd = 1'b1;
          @(negedge clk);
          buf_rd = 1'b0;
        end
      join
      idle(2);
      read_chk("R4", b, 1'b0, 1'b0);
      chk("R4", "empty after coincident read", rx_valid, 0);
    end

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule